// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a three-wire serial EEPROM slave holding 2048 bits in a register array. A host drives chip select, a serial clock and serial data in, and receives serial data out together with an output-enable that stands for the high-impedance state of the pin. A static strap picks the organization: 256 bytes, or 128 sixteen-bit words with one fewer address bit. All four serial inputs and the strap are resynchronized into a fast system clock domain. Serial-clock rising edges are found by edge detection in that domain.

Every instruction opens with a 1 start bit, then a 2-bit opcode, then the address field, then data for the write-type instructions. Reads shift out a dummy 0 followed by the addressed word. With chip select held high, reads carry on through higher addresses and wrap at the top of the array. Programming instructions are accepted only while a write-enable latch is set. A programming operation starts when chip select falls after a complete frame and then runs for a fixed number of system cycles. A host that raises chip select during or after that interval sees a busy/ready indication on the data output.

Top module: `mwire_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, `dout_en` is low and every byte of the array reads as 8'hFF.
- R2: `dout_en` is low whenever chip select is low. It is also low while chip select is high and neither a read nor the status display is active, for example while a frame is being shifted in.
- R3: READ is opcode 10. With `org_wide` low, the frame is the start bit, the opcode and eight address bits, all MSB first. On the serial-clock rise that takes the last address bit, `dout` shows a dummy 0 with `dout_en` high. Each later rise presents the next data bit, MSB first.
- R4: With `org_wide` high, the address field is seven bits and words are 16 bits wide. Word n is byte 2n (bits 15:8) followed by byte 2n+1 (bits 7:0).
- R5: While chip select stays high, a read continues with the word at the next higher address. After the last word it wraps to address 0.
- R6: WRITE, ERASE, write-all and erase-all have no effect unless the write-enable latch is set. Opcode 00 takes its sub-code from the two most significant address bits: 11 sets the latch and 00 clears it. READ works whatever the state of the latch.
- R7: WRITE is opcode 01, followed by one data word MSB first. The addressed word takes that data once the programming interval that starts at the next falling edge of chip select has elapsed.
- R8: ERASE is opcode 11 and sets the addressed word to all ones.
- R9: Sub-code 01 (write-all) takes one data word and copies it into every word. Sub-code 10 (erase-all) sets every word to all ones.
- R10: Programming lasts exactly PROG_CYCLES system cycles. While chip select is high and the status display is active, `dout` is 0 when busy and 1 when ready.
- R11: A serial-clock rise with chip select and data in both high ends the status display, and `dout_en` drops.
- R12: Zero bits shifted in before the start bit are ignored.
- R13: Start bits that arrive while programming is in progress are ignored, so a frame sent then changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial interface |
| rst_n | input | 1 | Synchronous active-low reset |
| org_wide | input | 1 | Organization strap: 0 selects bytes, 1 selects 16-bit words |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read data or busy/ready status |
| dout_en | output | 1 | Output enable for `dout`; low stands for high impedance |

## Verification
The checks assume that chip select, the serial clock and data in each stay at one level for longer than the synchronizer depth plus one system cycle. They also assume the organization strap changes only while chip select is low, so a frame never sees two field widths. The stimulus holds every half period of the serial clock for six system cycles and changes data in only while the serial clock is low. It moves the strap only between frames, after chip select has been low for several cycles. The checker takes the busy interval and the timing of the status indication as measured in system cycles from the falling edge of chip select as it was resynchronized.

// File: rtl/mw_pkg.sv
// Shared encodings for the three-wire serial EEPROM model.
// Assumes a byte-organized storage of 2**ABITS entries behind it.
package mw_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK  = 2'b00;
    localparam logic [1:0] SUB_FILL  = 2'b01;
    localparam logic [1:0] SUB_WIPE  = 2'b10;
    localparam logic [1:0] SUB_OPEN  = 2'b11;

    typedef enum logic [2:0] {
        PG_NONE,
        PG_WRITE,
        PG_FILL,
        PG_ERASE,
        PG_WIPE
    } prog_op_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_CMD,
        FS_DATA,
        FS_ARMED,
        FS_READ,
        FS_SKIP
    } fstate_t;
endpackage

// File: rtl/mw_sync.sv
// Multi-bit synchronizer: each bit goes through its own flop chain.
// Assumes the inputs are independent, slowly changing levels.
module mw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] pipe;
            // Shift the raw level one stage deeper each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= (pipe << 1) | STAGES'(d[i]);
            end
            assign q[i] = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mw_array.sv
// Storage array with a self-timed programming engine.
// A start pulse latches the operation. The array changes on the last cycle
// of a PROG_CYCLES-long busy interval. Reads are combinational.
// Assumes start is never pulsed while busy.
module mw_array
    import mw_pkg::*;
#(
    parameter int ABITS       = 8,
    parameter int PROG_CYCLES = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  prog_op_t          op,
    input  logic              wide,
    input  logic [ABITS-1:0]  addr,
    input  logic [WORD_W-1:0] data,
    input  logic [ABITS-1:0]  rd_addr,
    input  logic              rd_wide,
    output logic [WORD_W-1:0] rd_word,
    output logic              busy
);
    localparam int NBYTES = 1 << ABITS;
    localparam int CW     = $clog2(PROG_CYCLES + 1);

    logic [BYTE_W-1:0] mem [NBYTES];
    logic [CW-1:0]     cnt;
    prog_op_t          op_q;
    logic              wide_q;
    logic [ABITS-1:0]  addr_q;
    logic [WORD_W-1:0] data_q;
    logic              done;

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // True when byte bi belongs to the latched target word.
    function automatic logic hit(input logic [ABITS-1:0] bi);
        if (wide_q) return bi[ABITS-1:1] == addr_q[ABITS-2:0];
        else        return bi == addr_q;
    endfunction

    // Byte of the latched data that lands in byte bi.
    function automatic logic [BYTE_W-1:0] lane(input logic [ABITS-1:0] bi);
        if (wide_q) return bi[0] ? data_q[BYTE_W-1:0] : data_q[WORD_W-1:BYTE_W];
        else        return data_q[BYTE_W-1:0];
    endfunction

    // Interval timer and operation latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            op_q   <= PG_NONE;
            wide_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (start) begin
            cnt    <= CW'(PROG_CYCLES);
            op_q   <= op;
            wide_q <= wide;
            addr_q <= addr;
            data_q <= data;
        end else if (busy) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Array update on the final busy cycle; erased state at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= '1;
        end else if (done) begin
            for (int i = 0; i < NBYTES; i++) begin
                case (op_q)
                    PG_WRITE: if (hit(ABITS'(i))) mem[i] <= lane(ABITS'(i));
                    PG_FILL:  mem[i] <= lane(ABITS'(i));
                    PG_ERASE: if (hit(ABITS'(i))) mem[i] <= '1;
                    PG_WIPE:  mem[i] <= '1;
                    default:  ;
                endcase
            end
        end
    end

    // Combinational read of one byte or one byte pair.
    always_comb begin
        if (rd_wide)
            rd_word = {mem[{rd_addr[ABITS-2:0], 1'b0}], mem[{rd_addr[ABITS-2:0], 1'b1}]};
        else
            rd_word = {{(WORD_W-BYTE_W){1'b0}}, mem[rd_addr]};
    end
endmodule

// File: rtl/mw_frame.sv
// Serial frame engine: finds the start bit, collects opcode, address and data,
// holds the write-enable latch, streams read data and drives the status display.
// Assumes cs, di and wide are already synchronized, that sk_rise is a one-cycle
// pulse, and that wide is constant while cs is high.
module mw_frame
    import mw_pkg::*;
#(
    parameter int ABITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk_rise,
    input  logic              di,
    input  logic              wide,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ABITS-1:0]  rd_addr,
    output logic              start,
    output prog_op_t          op,
    output logic [ABITS-1:0]  addr,
    output logic [WORD_W-1:0] data,
    output logic              wen,
    output logic              rd_active,
    output logic              dout,
    output logic              dout_en
);
    localparam int CMD_LEN = 2 + ABITS;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int BIT_W   = $clog2(WORD_W);

    fstate_t           state;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] nxt;
    logic              cs_prev;
    logic              stat_show;
    logic              dout_q;
    logic [BIT_W-1:0]  bit_idx;
    logic              last_cmd;
    logic              last_dat;
    logic [1:0]        opc;
    logic [1:0]        sub;
    logic [ABITS-1:0]  a_dec;
    logic [ABITS-1:0]  a_mask;
    logic [BIT_W-1:0]  top_bit;

    // Field extraction from the shift register including the incoming bit.
    always_comb begin
        nxt      = {sr[WORD_W-2:0], di};
        last_cmd = (cnt == CNT_W'(wide ? CMD_LEN - 2 : CMD_LEN - 1));
        last_dat = (cnt == CNT_W'(wide ? WORD_W - 1 : BYTE_W - 1));
        opc      = wide ? nxt[ABITS:ABITS-1] : nxt[ABITS+1:ABITS];
        sub      = wide ? nxt[ABITS-2:ABITS-3] : nxt[ABITS-1:ABITS-2];
        a_dec    = wide ? {1'b0, nxt[ABITS-2:0]} : nxt[ABITS-1:0];
        a_mask   = wide ? {1'b0, {(ABITS-1){1'b1}}} : {ABITS{1'b1}};
        top_bit  = BIT_W'(wide ? WORD_W - 1 : BYTE_W - 1);
    end

    assign rd_active = (state == FS_READ);
    assign dout_en   = cs && (rd_active || stat_show);
    assign dout      = rd_active ? dout_q : !busy;

    // Frame sequencing, enable latch, read streaming and status flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FS_IDLE;
            cnt       <= '0;
            sr        <= '0;
            cs_prev   <= 1'b0;
            stat_show <= 1'b0;
            dout_q    <= 1'b0;
            bit_idx   <= '0;
            rd_addr   <= '0;
            start     <= 1'b0;
            op        <= PG_NONE;
            addr      <= '0;
            data      <= '0;
            wen       <= 1'b0;
        end else begin
            start   <= 1'b0;
            cs_prev <= cs;
            if (cs && sk_rise && di) stat_show <= 1'b0;
            if (!cs) begin
                state <= FS_IDLE;
                if (cs_prev && state == FS_ARMED) begin
                    start     <= 1'b1;
                    stat_show <= 1'b1;
                end
            end else if (sk_rise) begin
                case (state)
                    FS_IDLE: begin
                        if (di && !busy) begin
                            state <= FS_CMD;
                            cnt   <= '0;
                            sr    <= '0;
                        end
                    end
                    FS_CMD: begin
                        sr  <= nxt;
                        cnt <= cnt + CNT_W'(1);
                        if (last_cmd) begin
                            state <= FS_SKIP;
                            addr  <= a_dec;
                            case (opc)
                                OPC_READ: begin
                                    state   <= FS_READ;
                                    dout_q  <= 1'b0;
                                    rd_addr <= a_dec;
                                    bit_idx <= top_bit;
                                end
                                OPC_WRITE: if (wen) begin
                                    op    <= PG_WRITE;
                                    state <= FS_DATA;
                                    cnt   <= '0;
                                end
                                OPC_ERASE: if (wen) begin
                                    op    <= PG_ERASE;
                                    state <= FS_ARMED;
                                end
                                default: begin
                                    case (sub)
                                        SUB_OPEN: wen <= 1'b1;
                                        SUB_LOCK: wen <= 1'b0;
                                        SUB_FILL: if (wen) begin
                                            op    <= PG_FILL;
                                            state <= FS_DATA;
                                            cnt   <= '0;
                                        end
                                        default: if (wen) begin
                                            op    <= PG_WIPE;
                                            state <= FS_ARMED;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    FS_DATA: begin
                        sr  <= nxt;
                        cnt <= cnt + CNT_W'(1);
                        if (last_dat) begin
                            data  <= wide ? nxt : {{(WORD_W-BYTE_W){1'b0}}, nxt[BYTE_W-1:0]};
                            state <= FS_ARMED;
                        end
                    end
                    FS_READ: begin
                        dout_q <= rd_word[bit_idx];
                        if (bit_idx == '0) begin
                            bit_idx <= top_bit;
                            rd_addr <= (rd_addr + ABITS'(1)) & a_mask;
                        end else begin
                            bit_idx <= bit_idx - BIT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mwire_eeprom.sv
// Top level of the three-wire serial EEPROM model. Resynchronizes the serial
// pins and the organization strap, detects serial-clock rises, and joins
// the frame engine to the storage array.
// Assumes clk runs several times faster than the serial clock.
module mwire_eeprom
    import mw_pkg::*;
#(
    parameter int ABITS       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_wide,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_en
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0]  sync_q;
    logic              cs_s, sk_s, di_s, wide_s;
    logic              sk_prev;
    logic              sk_rise;
    logic              start_w, busy_w, wen_w, rd_act_w;
    prog_op_t          op_w;
    logic [ABITS-1:0]  addr_w, rd_addr_w;
    logic [WORD_W-1:0] data_w, rd_word_w;

    mw_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({org_wide, di, sk, cs}),
        .q     (sync_q)
    );

    assign {wide_s, di_s, sk_s, cs_s} = sync_q;

    // Delayed serial clock for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sk_prev <= 1'b0;
        else        sk_prev <= sk_s;
    end

    assign sk_rise = sk_s && !sk_prev;

    mw_frame #(.ABITS(ABITS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs_s),
        .sk_rise   (sk_rise),
        .di        (di_s),
        .wide      (wide_s),
        .busy      (busy_w),
        .rd_word   (rd_word_w),
        .rd_addr   (rd_addr_w),
        .start     (start_w),
        .op        (op_w),
        .addr      (addr_w),
        .data      (data_w),
        .wen       (wen_w),
        .rd_active (rd_act_w),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    mw_array #(.ABITS(ABITS), .PROG_CYCLES(PROG_CYCLES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .op      (op_w),
        .wide    (wide_s),
        .addr    (addr_w),
        .data    (data_w),
        .rd_addr (rd_addr_w),
        .rd_wide (wide_s),
        .rd_word (rd_word_w),
        .busy    (busy_w)
    );
endmodule

// File: rtl/mwire_eeprom_chk.sv
// Property checker for mwire_eeprom, attached with bind below.
// Assumes the serial pins are held stable longer than the synchronizer depth.
module mwire_eeprom_chk #(
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYCLES = 2500000
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic cs_s,
    input logic sk_rise,
    input logic dout,
    input logic dout_en,
    input logic busy,
    input logic start,
    input logic wen,
    input logic rd_active
);
    localparam int LW = $clog2(SYNC_STAGES + 3) + 1;

    logic [LW-1:0] low_cnt;
    logic [31:0]   run;

    // Consecutive cycles of raw chip select low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                               low_cnt <= '0;
        else if (cs)                              low_cnt <= '0;
        else if (low_cnt <= LW'(SYNC_STAGES + 1)) low_cnt <= low_cnt + LW'(1);
    end

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + 32'd1;
        else           run <= '0;
    end

    a_r2_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cnt > LW'(SYNC_STAGES)) |-> !dout_en);

    a_r10_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == 32'(PROG_CYCLES)));

    a_r6_program_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> wen);

    a_r13_start_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    a_r7_start_follows_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ($past(!cs_s) && $past(cs_s, 2)));

    a_r3_read_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active) && !$past(sk_rise)) |-> $stable(dout));
endmodule

bind mwire_eeprom mwire_eeprom_chk #(
    .SYNC_STAGES (SYNC_STAGES),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .cs_s      (cs_s),
    .sk_rise   (sk_rise),
    .dout      (dout),
    .dout_en   (dout_en),
    .busy      (busy_w),
    .start     (start_w),
    .wen       (wen_w),
    .rd_active (rd_act_w)
);

// File: tb/test_mwire_eeprom.sv
module test_mwire_eeprom;
    localparam int PROG = 1000;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org_wide = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout, dout_en;

    always #2 clk = ~clk;

    mwire_eeprom #(.ABITS(8), .SYNC_STAGES(2), .PROG_CYCLES(PROG)) i_mwire_eeprom (
        .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .cs(cs), .sk(sk), .di(di),
        .dout(dout), .dout_en(dout_en)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] model [256];
    logic en = 1'b0;
    logic so_o, so_oe;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        di = b;
        tick(HALF);
        sk = 1'b1;
        tick(HALF);
        so_o  = dout;
        so_oe = dout_en;
        sk = 1'b0;
    endtask

    task automatic cs_up();
        cs = 1'b1;
        tick(HALF);
    endtask

    task automatic cs_down();
        tick(2);
        cs = 1'b0;
        di = 1'b0;
        tick(8);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
    endtask

    task automatic send_cmd(input logic [1:0] opc, input int a);
        sk_bit(1'b1);
        send_bits({14'd0, opc}, 2);
        send_bits(16'(a), org_wide ? 7 : 8);
    endtask

    task automatic ext_cmd(input logic [1:0] sub);
        int aw;
        aw = org_wide ? 7 : 8;
        send_cmd(2'b00, int'(sub) << (aw - 2));
    endtask

    // Bench model of a finished programming operation on one word.
    task automatic put_word(input int a, input logic [15:0] d);
        if (org_wide) begin
            model[(a & 127) * 2]     = d[15:8];
            model[(a & 127) * 2 + 1] = d[7:0];
        end else begin
            model[a & 255] = d[7:0];
        end
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic apply, input string req);
        cs_up();
        send_cmd(2'b01, a);
        chk({req, " output off during frame (R2)"}, {31'd0, so_oe}, 32'd0);
        send_bits(d, org_wide ? 16 : 8);
        cs_down();
        if (en && apply) put_word(a, d);
    endtask

    task automatic read_seq(input int a, input int n, input int lead, input string req);
        logic [15:0] got, exp;
        int w, idx;
        w = org_wide ? 16 : 8;
        cs_up();
        repeat (lead) sk_bit(1'b0);
        send_cmd(2'b10, a);
        chk({req, " dummy zero (R3)"}, {30'd0, so_oe, so_o}, 32'd2);
        for (int k = 0; k < n; k++) begin
            got = '0;
            for (int b = 0; b < w; b++) begin
                sk_bit(1'b0);
                got = {got[14:0], so_o};
            end
            if (org_wide) begin
                idx = (a + k) & 127;
                exp = {model[idx * 2], model[idx * 2 + 1]};
            end else begin
                idx = (a + k) & 255;
                exp = {8'h00, model[idx]};
            end
            chk(req, 32'(got), 32'(exp));
        end
        cs_down();
    endtask

    task automatic prog_wait(input logic look);
        int t;
        if (!look) begin
            tick(PROG + 50);
        end else begin
            cs_up();
            chk("R10 status enabled", {31'd0, dout_en}, 32'd1);
            chk("R10 busy shows 0", {31'd0, dout}, 32'd0);
            t = 0;
            while (dout !== 1'b1 && t < 3 * PROG) begin
                tick(1);
                t++;
            end
            chk("R10 ready after interval", {31'd0, (t >= PROG - 40) && (t <= PROG + 10)}, 32'd1);
            chk("R10 ready shows 1", {31'd0, dout}, 32'd1);
            sk_bit(1'b1);
            chk("R11 status cleared", {31'd0, so_oe}, 32'd0);
            cs_down();
        end
    endtask

    initial begin
        tick(190000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 / R2: idle state after reset, erased array
        chk("R1 output off after reset", {31'd0, dout_en}, 32'd0);
        read_seq(0, 4, 0, "R1 erased contents");

        // R6: programming refused while disabled
        do_write(5, 16'h00A5, 1'b1, "R6");
        cs_up();
        chk("R6 no status after refused write", {31'd0, dout_en}, 32'd0);
        cs_down();
        read_seq(5, 1, 0, "R6 word unchanged");

        // R6 / R2: enable the latch, output stays off
        cs_up();
        ext_cmd(2'b11);
        chk("R2 off after enable frame", {31'd0, so_oe}, 32'd0);
        cs_down();
        en = 1'b1;

        // R7 / R10 / R11: a spread of byte writes
        for (int k = 0; k < 8; k++) begin
            do_write(k * 33 + 2, 16'((k * 33 + 2) * 7 + 8'h3C) & 16'h00FF, 1'b1, "R7");
            prog_wait(k < 2);
        end
        do_write(255, 16'h0081, 1'b1, "R7");
        prog_wait(1'b0);
        do_write(0, 16'h0042, 1'b1, "R7");
        prog_wait(1'b1);

        // R5: wrap from the top byte to zero
        read_seq(254, 4, 0, "R5 byte wrap");
        // R3 / R7: one read through the whole array
        read_seq(0, 256, 0, "R3 full dump");

        // R8: erase one byte
        cs_up();
        send_cmd(2'b11, 35);
        cs_down();
        model[35] = 8'hFF;
        prog_wait(1'b0);
        read_seq(34, 3, 0, "R8 erase");

        // R12: leading zeros before the start bit
        read_seq(68, 2, 3, "R12 leading zeros");

        // R13: frame sent during programming is ignored
        do_write(100, 16'h0011, 1'b1, "R13");
        do_write(101, 16'h0022, 1'b0, "R13");
        tick(PROG + 100);
        read_seq(100, 2, 0, "R13 busy frame ignored");

        // R4: word organization
        org_wide = 1'b1;
        tick(8);
        do_write(3, 16'h1234, 1'b1, "R4");
        prog_wait(1'b1);
        read_seq(3, 1, 0, "R4 word read");
        do_write(127, 16'hBEEF, 1'b1, "R4");
        prog_wait(1'b0);
        read_seq(126, 3, 0, "R5 word wrap");
        org_wide = 1'b0;
        tick(8);
        read_seq(6, 2, 0, "R4 byte order");

        // R9: write-all, then erase-all
        cs_up();
        ext_cmd(2'b01);
        send_bits(16'h005A, 8);
        cs_down();
        for (int i = 0; i < 256; i++) model[i] = 8'h5A;
        prog_wait(1'b1);
        read_seq(120, 16, 0, "R9 write-all");
        cs_up();
        ext_cmd(2'b10);
        cs_down();
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        prog_wait(1'b0);
        read_seq(250, 8, 0, "R9 erase-all");

        // R6: disable again, writes refused, reads still work
        do_write(9, 16'h0033, 1'b1, "R6");
        prog_wait(1'b0);
        cs_up();
        ext_cmd(2'b00);
        cs_down();
        en = 1'b0;
        do_write(10, 16'h0077, 1'b1, "R6");
        cs_up();
        chk("R6 no status after disable", {31'd0, dout_en}, 32'd0);
        cs_down();
        tick(PROG + 50);
        read_seq(9, 2, 0, "R6 read while disabled");

        summary();
    end
endmodule